// File: doc/BRIEF.md
# Word-Mapped GPIO Port with Bit-Set and Bit-Clear Access

This block is one general-purpose I/O port of between 1 and 32 lines. It sits behind a simple single-cycle 32-bit register bus. Line n maps to bit n of every register. The port holds two state registers: an output-level register and a drive-enable register. Software never writes either one with a plain value. Each register has one address where a 1 in the write word turns bits on, and a second address where a 1 turns bits off. One line can therefore be changed without reading the register first, and without racing against another agent that changes a different line.

The output-level bits drive the `pin_out` pads and the drive-enable bits drive `pin_oe` directly from flops. Each external pin level passes through a multi-flop synchronizer before software can read it. The drive-enable register has its own read-only view address. The address map is fixed:

- 0x000: turn output bits on.
- 0x004: turn output bits off.
- 0x010: turn drive-enable bits on.
- 0x014: turn drive-enable bits off.
- 0x018: drive-enable view.
- 0x080: pin-level view.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all zero, so every line is an input. A read of 0x018 or 0x080 also returns zero while the pins are held low.
- R2: A write to byte address 0x000 turns on every output-level bit whose write-data bit is 1 and leaves the other bits as they were. `pin_out` shows the new value after the rising edge that takes the write.
- R3: A write to 0x004 turns off every output-level bit whose write-data bit is 1 and leaves the other bits as they were. The change is visible on `pin_out` after the same edge.
- R4: Writes to 0x010 and 0x014 turn drive-enable bits on and off in the same bit-wise way. A 1 on `pin_oe[n]` means line n is driven.
- R5: A read (`bus_sel`=1, `bus_wr`=0) of 0x018 returns the drive-enable register in bits [LINES-1:0] in the same cycle.
- R6: A read of 0x080 returns the pin levels as they were sampled SYNC_STAGES rising edges earlier (two with the default).
- R7: Reads of 0x000, 0x004, 0x010 and 0x014 return zero. So does a read of any unmapped or non-word-aligned address. `bus_rdata` is zero in every cycle that is not a read.
- R8: A write to 0x018, to 0x080, or to any unmapped or non-word-aligned address changes neither register.
- R9: Bits at position LINES and above read as zero, and a 1 written there has no effect.
- R10: The output-level bits reach `pin_out` whatever the drive-enable setting is, so a level can be preset before a line is turned into an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| pin_in | input | LINES | External pin levels, asynchronous |
| pin_out | output | LINES | Output level per line |
| pin_oe | output | LINES | Drive enable per line |

## Verification
The two activities that can meet in one cycle are a change of the asynchronous pin levels and a bus access. The access can be a read of the pin-level view, or a set or clear write that moves `pin_out`. The bench changes `pin_in` in the very cycle it reads 0x080 or writes a register. It uses a pseudo-random pattern that toggles lines every cycle. A queue-free reference model delays the pin levels by two edges and applies the bit-wise writes. The model's read data and pad outputs are compared with the design in every cycle. A correct design returns the level that entered the synchronizer two edges earlier, never the level being presented now. Its register writes are not disturbed by the pin activity.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

   localparam int unsigned BUS_W = 32;

   // Byte offsets of the port's registers
   localparam logic [11:0] OFS_OUT_ON  = 12'h000;
   localparam logic [11:0] OFS_OUT_OFF = 12'h004;
   localparam logic [11:0] OFS_OE_ON   = 12'h010;
   localparam logic [11:0] OFS_OE_OFF  = 12'h014;
   localparam logic [11:0] OFS_OE_VIEW = 12'h018;
   localparam logic [11:0] OFS_PIN_VIEW = 12'h080;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_OUT_ON,
      TGT_OUT_OFF,
      TGT_OE_ON,
      TGT_OE_OFF,
      TGT_OE_VIEW,
      TGT_PIN_VIEW
   } gpio_target_e;

   typedef struct packed {
      logic on_we;
      logic off_we;
   } w1_ctrl_t;

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
   import gpio_sc_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output gpio_target_e      target
);

   localparam int unsigned OFS_W = 12;

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("gpio_sc_decode: ADDR_W must be at least 8");
      end
   endgenerate

   // Upper address bits beyond the map must be zero for a hit
   logic [OFS_W-1:0] ofs;
   logic             hi_zero;

   generate
      if (ADDR_W > OFS_W) begin : g_wide
         assign ofs     = addr[OFS_W-1:0];
         assign hi_zero = (addr[ADDR_W-1:OFS_W] == '0);
      end else begin : g_narrow
         assign ofs     = OFS_W'(addr);
         assign hi_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      target = TGT_NONE;
      if (sel && hi_zero) begin
         unique case (ofs)
            OFS_OUT_ON:   target = TGT_OUT_ON;
            OFS_OUT_OFF:  target = TGT_OUT_OFF;
            OFS_OE_ON:    target = TGT_OE_ON;
            OFS_OE_OFF:   target = TGT_OE_OFF;
            OFS_OE_VIEW:  target = TGT_OE_VIEW;
            OFS_PIN_VIEW: target = TGT_PIN_VIEW;
            default:      target = TGT_NONE;
         endcase
      end
   end

endmodule

// File: rtl/gpio_sc_w1_reg.sv
module gpio_sc_w1_reg
   import gpio_sc_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  w1_ctrl_t         ctrl,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1 || WIDTH > BUS_W) begin : g_bad_width
         $error("gpio_sc_w1_reg: WIDTH out of range");
      end
   endgenerate

   // One flop per line; set and clear never arrive together
   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q[b] <= 1'b0;
            end else if (ctrl.on_we && mask[b]) begin
               q[b] <= 1'b1;
            end else if (ctrl.off_we && mask[b]) begin
               q[b] <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("gpio_sc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   generate
      for (genvar k = 1; k < STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
   import gpio_sc_pkg::*;
#(
   parameter int unsigned LINES       = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [LINES-1:0]  pin_in,
   output logic [LINES-1:0]  pin_out,
   output logic [LINES-1:0]  pin_oe
);

   generate
      if (LINES < 1 || LINES > BUS_W) begin : g_bad_lines
         $error("gpio_setclr_port: LINES must be 1 to 32");
      end
   endgenerate

   gpio_target_e     target;
   w1_ctrl_t         out_ctrl;
   w1_ctrl_t         oe_ctrl;
   logic [LINES-1:0] wmask;
   logic [LINES-1:0] out_q;
   logic [LINES-1:0] oe_q;
   logic [LINES-1:0] pin_sync;
   logic             is_write;
   logic             is_read;

   // Bits above LINES are dropped here on purpose
   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   assign wmask    = bus_wdata[LINES-1:0];
   assign is_write = bus_sel &&  bus_wr;
   assign is_read  = bus_sel && !bus_wr;

   gpio_sc_decode #(.ADDR_W(ADDR_W)) u_dec (
      .sel    (bus_sel),
      .addr   (bus_addr),
      .target (target)
   );

   assign out_ctrl.on_we  = is_write && (target == TGT_OUT_ON);
   assign out_ctrl.off_we = is_write && (target == TGT_OUT_OFF);
   assign oe_ctrl.on_we   = is_write && (target == TGT_OE_ON);
   assign oe_ctrl.off_we  = is_write && (target == TGT_OE_OFF);

   gpio_sc_w1_reg #(.WIDTH(LINES)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .ctrl  (out_ctrl),
      .mask  (wmask),
      .q     (out_q)
   );

   gpio_sc_w1_reg #(.WIDTH(LINES)) u_oe (
      .clk   (clk),
      .rst_n (rst_n),
      .ctrl  (oe_ctrl),
      .mask  (wmask),
      .q     (oe_q)
   );

   gpio_sc_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   always_comb begin
      bus_rdata = '0;
      if (is_read) begin
         unique case (target)
            TGT_OE_VIEW:  bus_rdata = 32'(oe_q);
            TGT_PIN_VIEW: bus_rdata = 32'(pin_sync);
            default:      bus_rdata = '0;
         endcase
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = oe_q;

endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk #(
   parameter int unsigned LINES  = 32,
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [LINES-1:0]  pin_out,
   input logic [LINES-1:0]  pin_oe
);

   logic wr_out_on, wr_out_off, wr_oe_on, wr_oe_off, rd_oe_view;
   assign wr_out_on  = bus_sel && bus_wr  && (bus_addr == ADDR_W'(12'h000));
   assign wr_out_off = bus_sel && bus_wr  && (bus_addr == ADDR_W'(12'h004));
   assign wr_oe_on   = bus_sel && bus_wr  && (bus_addr == ADDR_W'(12'h010));
   assign wr_oe_off  = bus_sel && bus_wr  && (bus_addr == ADDR_W'(12'h014));
   assign rd_oe_view = bus_sel && !bus_wr && (bus_addr == ADDR_W'(12'h018));

   AST_RESET_ALL_INPUT: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0)); // R1

   AST_OUT_ON_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_out_on |=> pin_out == ($past(pin_out) | $past(bus_wdata[LINES-1:0]))); // R2

   AST_OUT_OFF_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_out_off |=> pin_out == ($past(pin_out) & ~$past(bus_wdata[LINES-1:0]))); // R3

   AST_OE_ON_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_oe_on |=> pin_oe == ($past(pin_oe) | $past(bus_wdata[LINES-1:0]))); // R4

   AST_OE_OFF_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_oe_off |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata[LINES-1:0]))); // R4

   AST_OE_VIEW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe_view |-> bus_rdata == 32'(pin_oe)); // R5

   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |-> bus_rdata == '0); // R7

   AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_out_on || wr_out_off || wr_oe_on || wr_oe_off)
      |=> ($stable(pin_out) && $stable(pin_oe))); // R8

   generate
      if (LINES < 32) begin : g_hi
         AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[31:LINES] == '0); // R9
      end
   endgenerate

endmodule

bind gpio_setclr_port gpio_setclr_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_setclr_port.sv
`timescale 1ns/1ps
module sim_gpio_setclr_port;

   localparam int NL = 20;
   localparam logic [31:0] LMASK = 32'h000F_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NL-1:0] pin_in = '0;
   logic [NL-1:0] pin_out;
   logic [NL-1:0] pin_oe;

   int checks = 0;
   int failures = 0;

   // reference state
   logic [31:0] m_out = '0;
   logic [31:0] m_oe = '0;
   logic [31:0] m_s1 = '0;
   logic [31:0] m_s2 = '0;

   always #2 clk = ~clk;

   gpio_setclr_port #(.LINES(NL), .ADDR_W(12), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic s, input logic w,
                                          input logic [11:0] a);
      if (!s || w) return 32'h0;
      case (a)
         12'h018: return m_oe;
         12'h080: return m_s2;
         default: return 32'h0;
      endcase
   endfunction

   // one bus cycle, checked before and after the edge
   task automatic step(input string tag, input logic s, input logic w,
                       input logic [11:0] a, input logic [31:0] wd,
                       input logic [NL-1:0] pin);
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd; pin_in = pin;
      #1;
      check(tag, "rdata", bus_rdata, m_read(s, w, a));
      @(posedge clk);
      if (s && w) begin
         case (a)
            12'h000: m_out = m_out | (wd & LMASK);
            12'h004: m_out = m_out & ~wd;
            12'h010: m_oe  = m_oe | (wd & LMASK);
            12'h014: m_oe  = m_oe & ~wd;
            default: ;
         endcase
      end
      m_s2 = m_s1;
      m_s1 = 32'(pin);
      @(negedge clk);
      check(tag, "pin_out", 32'(pin_out), m_out);
      check(tag, "pin_oe", 32'(pin_oe), m_oe);
   endtask

   task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
      step(tag, 1'b1, 1'b1, a, d, pin_in);
   endtask

   task automatic rd(input string tag, input logic [11:0] a);
      step(tag, 1'b1, 1'b0, a, 32'h0, pin_in);
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", "pin_out", 32'(pin_out), 32'h0);
      check("R1", "pin_oe", 32'(pin_oe), 32'h0);
      rd("R1", 12'h018);
      rd("R1", 12'h080);

      // R2: bits turned on accumulate
      wr("R2", 12'h000, 32'h0000_0005);
      wr("R2", 12'h000, 32'h0000_00F0);
      wr("R2", 12'h000, 32'h0000_0000);
      // R9: writes above the line count do nothing
      wr("R9", 12'h000, 32'hFFF0_0000);
      // R3: bits turned off
      wr("R3", 12'h004, 32'h0000_0004);
      wr("R3", 12'h004, 32'h0000_0000);
      // R10: output level visible with drive disabled
      check("R10", "pin_oe", 32'(pin_oe), 32'h0);
      check("R10", "pin_out", 32'(pin_out), 32'h0000_00F1);

      // R4 / R5: drive enables and their view
      wr("R4", 12'h010, 32'h0000_FF00);
      wr("R4", 12'h014, 32'h0000_0F00);
      rd("R5", 12'h018);
      wr("R9", 12'h010, 32'hFFFF_FFFF);
      rd("R9", 12'h018);
      wr("R4", 12'h014, 32'h000A_AAAA);
      rd("R5", 12'h018);

      // R7: write-only and unmapped addresses read zero
      rd("R7", 12'h000);
      rd("R7", 12'h004);
      rd("R7", 12'h010);
      rd("R7", 12'h014);
      rd("R7", 12'h008);
      rd("R7", 12'h019);
      rd("R7", 12'h100);
      step("R7", 1'b0, 1'b0, 12'h018, 32'h0, pin_in);
      step("R7", 1'b0, 1'b1, 12'h000, 32'hFFFF_FFFF, pin_in);

      // R8: writes that must not touch state
      wr("R8", 12'h018, 32'hFFFF_FFFF);
      wr("R8", 12'h080, 32'hFFFF_FFFF);
      wr("R8", 12'h008, 32'hFFFF_FFFF);
      wr("R8", 12'h002, 32'hFFFF_FFFF);
      wr("R8", 12'h001, 32'hFFFF_FFFF);
      wr("R8", 12'h100, 32'hFFFF_FFFF);
      wr("R8", 12'h804, 32'hFFFF_FFFF);

      // R6: pin changes in the same cycle as reads and writes
      lfsr = 32'hACE1_2468;
      for (int i = 0; i < 200; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         case (i % 4)
            0: step("R6", 1'b1, 1'b0, 12'h080, 32'h0, lfsr[NL-1:0]);
            1: step("R6", 1'b1, 1'b1, 12'h000, lfsr ^ 32'h5A5A_5A5A, lfsr[NL-1:0]);
            2: step("R6", 1'b1, 1'b0, 12'h080, 32'h0, ~lfsr[NL-1:0]);
            default: step("R6", 1'b1, 1'b1, 12'h004, {lfsr[15:0], lfsr[31:16]}, lfsr[NL-1:0]);
         endcase
      end
      step("R6", 1'b1, 1'b0, 12'h080, 32'h0, 20'hFFFFF);
      step("R6", 1'b1, 1'b0, 12'h080, 32'h0, 20'h00000);
      step("R6", 1'b1, 1'b0, 12'h080, 32'h0, 20'h00000);
      step("R9", 1'b1, 1'b0, 12'h080, 32'h0, 20'h00000);

      // R1: asynchronous reset returns everything to input
      wr("R1", 12'h010, 32'hFFFF_FFFF);
      rst_n = 1'b0;
      m_out = '0; m_oe = '0; m_s1 = '0; m_s2 = '0;
      #1;
      check("R1", "pin_out", 32'(pin_out), 32'h0);
      check("R1", "pin_oe", 32'(pin_oe), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      rd("R1", 12'h080);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule